// File: doc/BRIEF.md
# GPIO Expander Register Bank

This block is the register bank of an eight-pin general-purpose I/O expander. A serial front end, not part of this block, turns bus transactions into byte-wide strobes on a simple register port. The port has a pointer-load strobe with an address, a write strobe with write data, a read strobe, and a registered read-data output. The bank holds the pin direction, the per-pin input inversion, the pull-up enables, the output latch, the interrupt setup (enable, compare value, mode) and a small global configuration register. It drives the per-pin output enables, output values and pull-up requests.

Every access uses an internal register pointer. A pointer load sets the pointer, and an access in the same cycle uses the new address. In sequential mode the pointer then moves on by one after each byte transferred, so a front end can stream a block of registers in one burst. A separate interrupt block owns the flag and capture registers. This bank only returns their values on a read, and it sends that block a one-cycle clear pulse whenever the port or capture register is read.

Top module: `gpio_xp_regbank`

## Requirements
- R1: After reset, register 0x00 (direction) reads 0xFF and every other stored register reads 0x00. `pin_oe`, `pin_out` and `pull_en` are all zero, so every pin starts as an input.
- R2: For each pin n, `pin_oe[n]` is the inverse of direction bit n (1 means input). `pin_out[n]` is latch bit n when the pin is an output and 0 when it is an input. Registers 0x02, 0x03 and 0x04 drive `irq_en`, `irq_cmp` and `irq_mode` directly.
- R3: A read of address 0x09 (port) returns `pin_in` XOR the polarity register at 0x01.
- R4: A write to either 0x09 or 0x0A loads the output latch. A read of 0x0A returns the latch contents, whatever the levels on `pin_in`.
- R5: Reads of 0x07 and 0x08 return `irq_flags` and `irq_capt`. Writes to these two addresses change no register.
- R6: When configuration bit 5 is 0, each read or write moves the pointer to the next address, and 0x0A is followed by 0x00. An access at an address above 0x0A also leaves the pointer at 0x00.
- R7: When configuration bit 5 is 1, accesses leave the pointer where it is. The mode in force is the one from before the access, even when that access writes the configuration register.
- R8: The configuration register at 0x05 keeps only bits 5, 2 and 1, and its other bits read 0. `int_od` follows bit 2. `int_act_high` follows bit 1 only while bit 2 is 0.
- R9: Addresses above 0x0A read as 0x00, ignore writes and produce no clear pulse.
- R10: A read of 0x08 or 0x09 raises `int_clr` for exactly the one cycle after the read strobe. No other read and no idle cycle raises it.
- R11: `pull_en[n]` is pull-up bit n gated by direction bit n, so it is never set on an output pin.
- R12: A pointer load in the same cycle as an access makes that access use `bus_addr`. `bus_rdata` takes the read value at the clock edge that samples the read strobe and holds it until the next read.
- R13: If read and write strobes are set together, only the write is carried out. `bus_rdata` keeps its value, no clear pulse is sent, and the pointer advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_ptr_ld | input | 1 | Load the pointer from `bus_addr` this cycle |
| bus_addr | input | ADDR_W | Register address for a pointer load |
| bus_wr | input | 1 | Write strobe, one byte |
| bus_rd | input | 1 | Read strobe, one byte |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| pin_in | input | NPINS | Sampled pin levels |
| pin_oe | output | NPINS | Per-pin output enable |
| pin_out | output | NPINS | Per-pin output value |
| pull_en | output | NPINS | Per-pin pull-up request |
| irq_flags | input | NPINS | Flag register from the interrupt block |
| irq_capt | input | NPINS | Capture register from the interrupt block |
| irq_en | output | NPINS | Interrupt enable per pin |
| irq_cmp | output | NPINS | Compare value per pin |
| irq_mode | output | NPINS | Per pin, 1 selects compare mode and 0 selects change mode |
| int_od | output | 1 | Interrupt line is open-drain |
| int_act_high | output | 1 | Interrupt line is active high (push-pull only) |
| int_clr | output | 1 | One-cycle clear pulse to the interrupt block |

## Verification
In a single cycle the bank can load the pointer, carry out an access, and advance the pointer. The same cycle can also carry both a write and a read strobe. The bench drives these overlaps on purpose. It loads an address together with a read, and it sets both strobes while the pointer is being loaded. It also writes the configuration register with the mode bit flipped, to check that the pointer follows the mode from before the write. A scoreboard model judges each case by the next read's data and by the presence or absence of the clear pulse.

// File: rtl/xp_pkg.sv
package xp_pkg;
   localparam int XP_IDX_W    = 4;
   localparam int XP_LAST_IDX = 10;

   typedef enum logic [XP_IDX_W-1:0] {
      XR_DIR   = 4'd0,
      XR_POL   = 4'd1,
      XR_IEN   = 4'd2,
      XR_CMP   = 4'd3,
      XR_IMODE = 4'd4,
      XR_CFG   = 4'd5,
      XR_PULL  = 4'd6,
      XR_FLAG  = 4'd7,
      XR_CAPT  = 4'd8,
      XR_PORT  = 4'd9,
      XR_LAT   = 4'd10
   } xp_reg_e;

   localparam int XP_CFG_SEQOFF_BIT = 5;
   localparam int XP_CFG_OD_BIT     = 2;
   localparam int XP_CFG_POL_BIT    = 1;
endpackage

// File: rtl/xp_ptr_ctl.sv
module xp_ptr_ctl #(
   parameter int ADDR_W = 8,
   parameter int LAST   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              acc,
   input  logic              seq_en,
   output logic [ADDR_W-1:0] eff_addr,
   output logic [ADDR_W-1:0] ptr_q
);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST);

   logic [ADDR_W-1:0] nxt_addr;
   logic [ADDR_W-1:0] ptr_d;

   // the access of this cycle uses a freshly loaded address
   assign eff_addr = ld ? ld_addr : ptr_q;
   assign nxt_addr = (eff_addr >= LAST_A) ? '0 : eff_addr + ADDR_W'(1);
   assign ptr_d    = (acc && seq_en) ? nxt_addr : eff_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end
endmodule

// File: rtl/xp_reg_file.sv
module xp_reg_file
   import xp_pkg::*;
#(
   parameter int NPINS  = 8,
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [XP_IDX_W-1:0] idx,
   input  logic [DATA_W-1:0]   wdata,
   output logic [NPINS-1:0]    dir,
   output logic [NPINS-1:0]    pol,
   output logic [NPINS-1:0]    ien,
   output logic [NPINS-1:0]    cmp,
   output logic [NPINS-1:0]    imode,
   output logic [NPINS-1:0]    pull,
   output logic [NPINS-1:0]    lat,
   output logic                cfg_seqoff,
   output logic                cfg_od,
   output logic                cfg_pol,
   output logic [NPINS-1:0]    pin_oe,
   output logic [NPINS-1:0]    pin_out,
   output logic [NPINS-1:0]    pull_en
);
   logic [NPINS-1:0] wv;
   assign wv = wdata[NPINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir        <= '1;
         pol        <= '0;
         ien        <= '0;
         cmp        <= '0;
         imode      <= '0;
         pull       <= '0;
         lat        <= '0;
         cfg_seqoff <= 1'b0;
         cfg_od     <= 1'b0;
         cfg_pol    <= 1'b0;
      end else if (we) begin
         case (idx)
            XR_DIR:   dir   <= wv;
            XR_POL:   pol   <= wv;
            XR_IEN:   ien   <= wv;
            XR_CMP:   cmp   <= wv;
            XR_IMODE: imode <= wv;
            XR_PULL:  pull  <= wv;
            XR_CFG: begin
               cfg_seqoff <= wdata[XP_CFG_SEQOFF_BIT];
               cfg_od     <= wdata[XP_CFG_OD_BIT];
               cfg_pol    <= wdata[XP_CFG_POL_BIT];
            end
            XR_PORT, XR_LAT: lat <= wv;
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign pin_oe[i]  = ~dir[i];
      assign pin_out[i] = dir[i] ? 1'b0 : lat[i];
      assign pull_en[i] = pull[i] & dir[i];
   end
endmodule

// File: rtl/xp_rd_sel.sv
module xp_rd_sel
   import xp_pkg::*;
#(
   parameter int NPINS  = 8,
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_go,
   input  logic                addr_ok,
   input  logic [XP_IDX_W-1:0] idx,
   input  logic [NPINS-1:0]    dir,
   input  logic [NPINS-1:0]    pol,
   input  logic [NPINS-1:0]    ien,
   input  logic [NPINS-1:0]    cmp,
   input  logic [NPINS-1:0]    imode,
   input  logic [NPINS-1:0]    pull,
   input  logic [NPINS-1:0]    lat,
   input  logic [NPINS-1:0]    pin_in,
   input  logic [NPINS-1:0]    flags,
   input  logic [NPINS-1:0]    capt,
   input  logic                cfg_seqoff,
   input  logic                cfg_od,
   input  logic                cfg_pol,
   output logic [DATA_W-1:0]   rdata,
   output logic                int_clr
);
   logic [DATA_W-1:0] cfg_b;
   logic [DATA_W-1:0] sel;
   logic              clr_hit;

   always_comb begin
      cfg_b = '0;
      cfg_b[XP_CFG_SEQOFF_BIT] = cfg_seqoff;
      cfg_b[XP_CFG_OD_BIT]     = cfg_od;
      cfg_b[XP_CFG_POL_BIT]    = cfg_pol;
   end

   always_comb begin
      sel = '0;
      if (addr_ok) begin
         case (idx)
            XR_DIR:   sel = DATA_W'(dir);
            XR_POL:   sel = DATA_W'(pol);
            XR_IEN:   sel = DATA_W'(ien);
            XR_CMP:   sel = DATA_W'(cmp);
            XR_IMODE: sel = DATA_W'(imode);
            XR_CFG:   sel = cfg_b;
            XR_PULL:  sel = DATA_W'(pull);
            XR_FLAG:  sel = DATA_W'(flags);
            XR_CAPT:  sel = DATA_W'(capt);
            XR_PORT:  sel = DATA_W'(pin_in ^ pol);
            XR_LAT:   sel = DATA_W'(lat);
            default:  sel = '0;
         endcase
      end
   end

   assign clr_hit = addr_ok && ((idx == XR_PORT) || (idx == XR_CAPT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata   <= '0;
         int_clr <= 1'b0;
      end else begin
         if (rd_go) rdata <= sel;
         int_clr <= rd_go && clr_hit;
      end
   end
endmodule

// File: rtl/gpio_xp_regbank.sv
module gpio_xp_regbank
   import xp_pkg::*;
#(
   parameter int NPINS  = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_ptr_ld,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_oe,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pull_en,
   input  logic [NPINS-1:0]  irq_flags,
   input  logic [NPINS-1:0]  irq_capt,
   output logic [NPINS-1:0]  irq_en,
   output logic [NPINS-1:0]  irq_cmp,
   output logic [NPINS-1:0]  irq_mode,
   output logic              int_od,
   output logic              int_act_high,
   output logic              int_clr
);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(XP_LAST_IDX);

   if (NPINS > DATA_W) begin : g_bad_npins
      $error("NPINS must not exceed DATA_W");
   end
   if (ADDR_W < XP_IDX_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end
   if (DATA_W <= XP_CFG_SEQOFF_BIT) begin : g_bad_data
      $error("DATA_W too narrow for the configuration register");
   end

   logic [ADDR_W-1:0]   eff_addr;
   logic [ADDR_W-1:0]   ptr_q;
   logic [XP_IDX_W-1:0] idx;
   logic                addr_ok;
   logic                rd_go;
   logic                acc;
   logic                seq_en;
   logic                cfg_seqoff, cfg_od, cfg_pol;
   logic [NPINS-1:0]    dir, pol, pull, lat;

   assign acc     = bus_wr | bus_rd;
   assign rd_go   = bus_rd & ~bus_wr;
   assign seq_en  = ~cfg_seqoff;
   assign addr_ok = (eff_addr <= LAST_A);
   assign idx     = eff_addr[XP_IDX_W-1:0];

   xp_ptr_ctl #(.ADDR_W(ADDR_W), .LAST(XP_LAST_IDX)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (bus_ptr_ld),
      .ld_addr  (bus_addr),
      .acc      (acc),
      .seq_en   (seq_en),
      .eff_addr (eff_addr),
      .ptr_q    (ptr_q)
   );

   xp_reg_file #(.NPINS(NPINS), .DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (bus_wr & addr_ok),
      .idx        (idx),
      .wdata      (bus_wdata),
      .dir        (dir),
      .pol        (pol),
      .ien        (irq_en),
      .cmp        (irq_cmp),
      .imode      (irq_mode),
      .pull       (pull),
      .lat        (lat),
      .cfg_seqoff (cfg_seqoff),
      .cfg_od     (cfg_od),
      .cfg_pol    (cfg_pol),
      .pin_oe     (pin_oe),
      .pin_out    (pin_out),
      .pull_en    (pull_en)
   );

   xp_rd_sel #(.NPINS(NPINS), .DATA_W(DATA_W)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_go      (rd_go),
      .addr_ok    (addr_ok),
      .idx        (idx),
      .dir        (dir),
      .pol        (pol),
      .ien        (irq_en),
      .cmp        (irq_cmp),
      .imode      (irq_mode),
      .pull       (pull),
      .lat        (lat),
      .pin_in     (pin_in),
      .flags      (irq_flags),
      .capt       (irq_capt),
      .cfg_seqoff (cfg_seqoff),
      .cfg_od     (cfg_od),
      .cfg_pol    (cfg_pol),
      .rdata      (bus_rdata),
      .int_clr    (int_clr)
   );

   assign int_od       = cfg_od;
   assign int_act_high = cfg_pol & ~cfg_od;
endmodule

// File: rtl/gpio_xp_regbank_chk.sv
module gpio_xp_regbank_chk #(
   parameter int NPINS  = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_ptr_ld,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NPINS-1:0]  pin_oe,
   input logic [NPINS-1:0]  pull_en,
   input logic              int_clr,
   input logic [ADDR_W-1:0] ptr_q,
   input logic              seq_en
);
   p_reset_inputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0));

   p_pull_only_inputs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & pull_en) == '0);

   p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && !bus_wr) |=> $stable(bus_rdata));

   p_clr_needs_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      int_clr |-> $past(bus_rd && !bus_wr));

   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ptr_ld && !seq_en) |=> $stable(ptr_q));
endmodule

bind gpio_xp_regbank gpio_xp_regbank_chk #(
   .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_ptr_ld (bus_ptr_ld),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_rdata  (bus_rdata),
   .pin_oe     (pin_oe),
   .pull_en    (pull_en),
   .int_clr    (int_clr),
   .ptr_q      (ptr_q),
   .seq_en     (seq_en)
);

// File: tb/tb_gpio_xp_regbank.sv
module tb_gpio_xp_regbank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_ptr_ld = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_oe, pin_out, pull_en;
   logic [7:0] irq_flags = '0;
   logic [7:0] irq_capt = '0;
   logic [7:0] irq_en, irq_cmp, irq_mode;
   logic       int_od, int_act_high, int_clr;

   int errors = 0;
   int checks = 0;

   typedef struct {
      logic [7:0] d;
      logic       c;
      string      tag;
   } exp_t;
   exp_t exq[$];

   logic [7:0] m [0:10];
   int         ptr = 0;

   always #5 clk = ~clk;

   gpio_xp_regbank dut (
      .clk(clk), .rst_n(rst_n), .bus_ptr_ld(bus_ptr_ld), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pull_en(pull_en),
      .irq_flags(irq_flags), .irq_capt(irq_capt), .irq_en(irq_en), .irq_cmp(irq_cmp),
      .irq_mode(irq_mode), .int_od(int_od), .int_act_high(int_act_high), .int_clr(int_clr)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] mread(input int a);
      case (a)
         7:       return irq_flags;
         8:       return irq_capt;
         9:       return pin_in ^ m[1];
         default: return m[a];
      endcase
   endfunction

   // driver: one bus cycle, expected reads pushed to the scoreboard
   task automatic op(input bit ld, input int addr, input bit wr, input bit rd,
                     input logic [7:0] wd, input string tag);
      int   eff;
      bit   ok;
      bit   seq;
      exp_t e;
      @(negedge clk);
      bus_ptr_ld = ld; bus_addr = 8'(addr); bus_wr = wr; bus_rd = rd; bus_wdata = wd;
      eff = ld ? addr : ptr;
      ok  = (eff <= 10);
      seq = !m[5][5];
      if (rd && !wr) begin
         e.d = ok ? mread(eff) : 8'h00;
         e.c = ok && (eff == 8 || eff == 9);
         e.tag = tag;
         exq.push_back(e);
      end
      if (wr && ok) begin
         case (eff)
            5:       m[5] = wd & 8'h26;
            7, 8:    ;
            9, 10:   m[10] = wd;
            default: m[eff] = wd;
         endcase
      end
      if ((wr || rd) && seq) ptr = (eff >= 10) ? 0 : eff + 1;
      else                   ptr = eff;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bus_ptr_ld = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
      end
   endtask

   // monitor: compares each read result one cycle after its strobe
   always begin
      bit   p;
      exp_t e;
      @(posedge clk);
      p = rst_n && bus_rd && !bus_wr;
      @(negedge clk);
      if (p) begin
         if (exq.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: read with no expectation, actual=%02h expected=none", bus_rdata);
         end else begin
            e = exq.pop_front();
            chk(bus_rdata, e.d, {e.tag, " data"});
            chk(8'(int_clr), 8'(e.c), {e.tag, " R10 clear pulse"});
         end
      end else if (rst_n && int_clr) begin
         checks++; errors++;
         $display("FAIL R10: clear pulse without read, actual=1 expected=0");
      end
   end

   initial begin
      repeat (2000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      m[0] = 8'hFF;
      for (int i = 1; i <= 10; i++) m[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state at the ports
      chk(pin_oe, 8'h00, "R1 pin_oe");
      chk(pin_out, 8'h00, "R1 pin_out");
      chk(pull_en, 8'h00, "R1 pull_en");
      chk(8'(int_od), 8'h00, "R1 int_od");
      chk(irq_en, 8'h00, "R1 irq_en");

      // R1/R6: sweep all registers sequentially, then wrap to 0x00
      op(1, 0, 0, 1, 0, "R1 R12 read");
      for (int i = 0; i < 10; i++) op(0, 0, 0, 1, 0, "R6 seq read");
      op(0, 0, 0, 1, 0, "R6 wrap read");
      idle(1);

      // R2/R4: direction and latch through port address
      op(1, 0, 1, 0, 8'h0F, "R2");
      op(1, 9, 1, 0, 8'hA5, "R4");
      idle(1);
      chk(pin_oe, 8'hF0, "R2 pin_oe");
      chk(pin_out, 8'hA0, "R2 pin_out");
      op(1, 2, 1, 0, 8'h11, "R2");
      op(0, 0, 1, 0, 8'h22, "R2");
      op(0, 0, 1, 0, 8'h33, "R2");
      idle(1);
      chk(irq_en, 8'h11, "R2 irq_en");
      chk(irq_cmp, 8'h22, "R2 irq_cmp");
      chk(irq_mode, 8'h33, "R2 irq_mode");

      // R4 latch read ignores pins, R3 port read inverts per polarity
      pin_in = 8'h3C;
      op(1, 10, 0, 1, 0, "R4 latch read");
      op(1, 1, 1, 0, 8'h81, "R3");
      op(1, 9, 0, 1, 0, "R3 port read");
      idle(1);

      // R11 pull-ups only on inputs
      op(1, 6, 1, 0, 8'hFF, "R11");
      idle(1);
      chk(pull_en, 8'h0F, "R11 pull_en");

      // R5 read-only flag/capture registers
      irq_flags = 8'h12; irq_capt = 8'h34;
      op(1, 7, 1, 0, 8'h55, "R5");
      op(0, 0, 1, 0, 8'hAA, "R5");
      op(1, 7, 0, 1, 0, "R5 flags read");
      op(0, 0, 0, 1, 0, "R5 capture read");
      op(1, 0, 0, 1, 0, "R5 dir intact");
      op(1, 10, 0, 1, 0, "R5 latch intact");
      idle(1);

      // R8 config masking and INT outputs, R7 pointer hold
      op(1, 5, 1, 0, 8'hFF, "R8");
      idle(1);
      chk(8'(int_od), 8'h01, "R8 int_od");
      chk(8'(int_act_high), 8'h00, "R8 int_act_high under open-drain");
      op(1, 5, 0, 1, 0, "R8 cfg read");
      op(0, 0, 0, 1, 0, "R7 hold read");
      op(0, 0, 0, 1, 0, "R7 hold read");
      op(0, 0, 1, 0, 8'h02, "R7 R8");
      idle(1);
      chk(8'(int_od), 8'h00, "R8 int_od");
      chk(8'(int_act_high), 8'h01, "R8 int_act_high");
      op(0, 0, 0, 1, 0, "R7 old mode kept");
      op(0, 0, 0, 1, 0, "R6 seq resumed");
      idle(1);

      // R9 out-of-range addresses
      op(1, 12, 1, 0, 8'h77, "R9");
      op(1, 8'h19, 1, 0, 8'h00, "R9");
      op(1, 8'h19, 0, 1, 0, "R9 high read");
      op(0, 0, 0, 1, 0, "R6 R9 wrap read");
      op(1, 10, 0, 1, 0, "R9 latch intact");
      idle(1);

      // R13 simultaneous read and write; R12 data hold
      op(1, 1, 1, 1, 8'h5A, "R13");
      idle(2);
      chk(bus_rdata, 8'hA5, "R13 R12 rdata held");
      op(0, 0, 0, 1, 0, "R13 pointer advanced");
      op(1, 1, 0, 1, 0, "R13 write done");
      idle(3);
      chk(bus_rdata, 8'h5A, "R12 rdata hold");
      op(1, 9, 0, 1, 0, "R3 port read");
      idle(3);

      if (exq.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: pending=%0d expected=0", exq.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule